// File: doc/BRIEF.md
# Exception Priority Selector with Debug Promotion

This block sits at the memory/execute boundary of a simple in-order processor. Every clock it looks at a set of already decoded exception requests and picks exactly one winner by a fixed priority. The requests are trap, system call, vector floating-point data and rounding, alignment, data translation miss, data storage fault, and a group of debug events. The debug events are interrupt-taken, critical-interrupt-taken, a linked or unlinked data address compare, and instruction-complete. The registered result gives a take strobe, a one-hot winner vector, the vector offset register index to jump through, and whether the saved program counter should be the current instruction or the next one.

A data address compare is normally a post-instruction debug exception, so it ranks low and saves the address of the next instruction. When such a compare lands on a load or store that also takes a data translation miss or a data storage fault, the compare is promoted above both faults. It is then treated as imprecise: it saves the load/store's own address and sets a sticky imprecise-debug status bit, which software clears by writing one.

Requests are level flags that are sampled at each rising clock edge. No stream flows through the block, so it has no valid/ready handshake and no back-pressure. The result for the flags sampled at an edge is visible for exactly the following cycle.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `take`, `win_onehot`, `vec_idx`, `save_next` and `ide_flag` are all 0.
- R2: The flags sampled at a rising edge produce `take`, `win_onehot`, `vec_idx` and `save_next` for the one cycle after that edge. If no class is requesting, `take` is 0, `win_onehot` is 0 and `ide_flag` keeps its value.
- R3: Exactly one class wins. Its `win_onehot` bit is, from highest to lowest priority: bit0 trap, bit1 system call, bit2 vector FP data, bit3 vector FP round, bit4 alignment, bit5 concurrent linked compare, bit6 concurrent unlinked compare, bit7 data translation miss, bit8 data storage, bit9 debug interrupt-taken, bit10 debug critical-interrupt-taken, bit11 post linked compare, bit12 post unlinked compare, bit13 instruction complete.
- R4: `vec_idx` is 6 for trap, 8 for system call, 33 for FP data, 34 for FP round, 5 for alignment, 13 for translation miss, 2 for data storage, and 15 for every debug class.
- R5: A debug event is a request only when `dbg_enable`=1, `dbg_internal_mode`=1 and its bit in `ev_en` is 1. The `ev_en` bits are: bit0 interrupt-taken, bit1 critical-taken, bit2 linked compare, bit3 unlinked compare, bit4 instruction complete.
- R6: A qualified compare that arrives together with a translation miss or storage fault wins over both faults, with `vec_idx`=15 and `save_next`=0, and it sets `ide_flag`. A linked compare ranks above an unlinked one.
- R7: A qualified compare with no concurrent translation or storage fault is taken below the debug interrupt events with `save_next`=1. It leaves `ide_flag` unchanged.
- R8: Alignment is requested by `lsm_misalign` (a multiple or reservation load/store that is not word aligned) or by `bzero_nocache` (a block-zero with the cache off or absent).
- R9: A data storage fault is requested by `acc_violation`, by `endian_split`, or by `bus_err` only when `ext_int_en`=1.
- R10: `trap_hit` requests a trap only while `trap_as_dbg`=0.
- R11: Critical-interrupt-taken is a request only when `crit_irq`=1. Interrupt-taken ranks above it.
- R12: `ide_flag` stays set until a cycle with `ide_clr`=1 clears it. A new setting in the same cycle wins over the clear.
- R13: `save_next` is 1 for system call, post-instruction compares and instruction complete, and 0 for every other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_hit | input | 1 | Trap condition met |
| trap_as_dbg | input | 1 | Trap is being taken as a debug trap event instead |
| syscall | input | 1 | System call executed |
| vfp_data | input | 1 | Vector FP data exception |
| vfp_round | input | 1 | Vector FP inexact/round exception |
| lsm_misalign | input | 1 | Multiple or reservation access not word aligned |
| bzero_nocache | input | 1 | Block-zero with cache disabled or absent |
| tlb_miss | input | 1 | Data translation miss |
| acc_violation | input | 1 | Data access-control violation |
| endian_split | input | 1 | Misaligned access into a page of other endianness |
| bus_err | input | 1 | Precise external bus error |
| ext_int_en | input | 1 | External interrupts enabled |
| dbg_enable | input | 1 | Machine-state debug enable |
| dbg_internal_mode | input | 1 | Internal debug mode selected |
| ev_en | input | 5 | Per-event debug enables, bits as in R5 |
| ev_irq_taken | input | 1 | Debug event: interrupt taken |
| ev_crit_taken | input | 1 | Debug event: critical interrupt taken |
| crit_irq | input | 1 | The interrupt being taken is critical |
| ev_dac_linked | input | 1 | Data address compare linked with instruction compare |
| ev_dac_unlinked | input | 1 | Unlinked data address compare |
| ev_icmp | input | 1 | Instruction complete debug event |
| ide_clr | input | 1 | Write-one-to-clear for `ide_flag` |
| take | output | 1 | An exception is taken this cycle |
| win_onehot | output | 14 | Winning class, bits as in R3 |
| vec_idx | output | 6 | Vector offset register index |
| save_next | output | 1 | 1 = save next instruction address, 0 = current |
| ide_flag | output | 1 | Sticky imprecise-debug status |

## Verification
Each class is first driven alone, which separates the vector index, the save selection and the winner bit for every class. Adjacent pairs and a full-house pattern are then driven, which show each step of the priority chain. The compare events are tried with and without a concurrent translation or storage fault, which tells the promoted imprecise path (current address, sticky flag) apart from the post-instruction path. Gating patterns clear one enable at a time, cover every source of alignment and storage faults, cover the trap and critical qualifiers, and cover set-versus-clear of the status flag. Together they show which input really controls each request.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCLS  = 14;
  localparam int VEC_W = 6;
  localparam int NEV   = 5;

  // class positions, highest priority first
  localparam int C_TRAP  = 0;
  localparam int C_SC    = 1;
  localparam int C_VFPD  = 2;
  localparam int C_VFPR  = 3;
  localparam int C_ALIGN = 4;
  localparam int C_CDACL = 5;
  localparam int C_CDACU = 6;
  localparam int C_TLB   = 7;
  localparam int C_DSTOR = 8;
  localparam int C_DIRQ  = 9;
  localparam int C_DCIRQ = 10;
  localparam int C_PDACL = 11;
  localparam int C_PDACU = 12;
  localparam int C_ICMP  = 13;

  // debug event enable bit positions
  localparam int EV_IRQ  = 0;
  localparam int EV_CRIT = 1;
  localparam int EV_DACL = 2;
  localparam int EV_DACU = 3;
  localparam int EV_ICMP = 4;

  localparam logic [VEC_W-1:0] V_TRAP  = VEC_W'(6);
  localparam logic [VEC_W-1:0] V_SC    = VEC_W'(8);
  localparam logic [VEC_W-1:0] V_VFPD  = VEC_W'(33);
  localparam logic [VEC_W-1:0] V_VFPR  = VEC_W'(34);
  localparam logic [VEC_W-1:0] V_ALIGN = VEC_W'(5);
  localparam logic [VEC_W-1:0] V_TLB   = VEC_W'(13);
  localparam logic [VEC_W-1:0] V_DSTOR = VEC_W'(2);
  localparam logic [VEC_W-1:0] V_DEBUG = VEC_W'(15);

  typedef logic [NCLS-1:0] cls_vec_t;

  function automatic logic [VEC_W-1:0] class_vec(input int c);
    case (c)
      C_TRAP:  return V_TRAP;
      C_SC:    return V_SC;
      C_VFPD:  return V_VFPD;
      C_VFPR:  return V_VFPR;
      C_ALIGN: return V_ALIGN;
      C_TLB:   return V_TLB;
      C_DSTOR: return V_DSTOR;
      default: return V_DEBUG;
    endcase
  endfunction

  function automatic logic class_next(input int c);
    return (c == C_SC) || (c == C_PDACL) || (c == C_PDACU) || (c == C_ICMP);
  endfunction
endpackage

// File: rtl/exc_req_qualify.sv
module exc_req_qualify
  import exc_pkg::*;
(
  input  logic           trap_hit,
  input  logic           trap_as_dbg,
  input  logic           syscall,
  input  logic           vfp_data,
  input  logic           vfp_round,
  input  logic           lsm_misalign,
  input  logic           bzero_nocache,
  input  logic           tlb_miss,
  input  logic           acc_violation,
  input  logic           endian_split,
  input  logic           bus_err,
  input  logic           ext_int_en,
  input  logic           dbg_enable,
  input  logic           dbg_internal_mode,
  input  logic [NEV-1:0] ev_en,
  input  logic           ev_irq_taken,
  input  logic           ev_crit_taken,
  input  logic           crit_irq,
  input  logic           ev_dac_linked,
  input  logic           ev_dac_unlinked,
  input  logic           ev_icmp,
  output cls_vec_t       req
);
  logic dbg_ok;
  logic fault_tlb, fault_stor, fault_any;
  logic dacl_q, dacu_q;

  assign dbg_ok     = dbg_enable & dbg_internal_mode;
  assign fault_tlb  = tlb_miss;
  assign fault_stor = acc_violation | endian_split | (bus_err & ext_int_en);
  assign fault_any  = fault_tlb | fault_stor;
  assign dacl_q     = dbg_ok & ev_en[EV_DACL] & ev_dac_linked;
  assign dacu_q     = dbg_ok & ev_en[EV_DACU] & ev_dac_unlinked;

  always_comb begin
    req          = '0;
    req[C_TRAP]  = trap_hit & ~trap_as_dbg;
    req[C_SC]    = syscall;
    req[C_VFPD]  = vfp_data;
    req[C_VFPR]  = vfp_round;
    req[C_ALIGN] = lsm_misalign | bzero_nocache;
    req[C_CDACL] = dacl_q & fault_any;
    req[C_CDACU] = dacu_q & fault_any;
    req[C_TLB]   = fault_tlb;
    req[C_DSTOR] = fault_stor;
    req[C_DIRQ]  = dbg_ok & ev_en[EV_IRQ] & ev_irq_taken;
    req[C_DCIRQ] = dbg_ok & ev_en[EV_CRIT] & ev_crit_taken & crit_irq;
    req[C_PDACL] = dacl_q & ~fault_any;
    req[C_PDACU] = dacu_q & ~fault_any;
    req[C_ICMP]  = dbg_ok & ev_en[EV_ICMP] & ev_icmp;
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 14
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]       = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];
endmodule

// File: rtl/exc_vec_encode.sv
module exc_vec_encode
  import exc_pkg::*;
(
  input  cls_vec_t         gnt,
  output logic [VEC_W-1:0] vec,
  output logic             save_nxt,
  output logic             imprecise
);
  always_comb begin
    vec       = '0;
    save_nxt  = 1'b0;
    for (int i = 0; i < NCLS; i++) begin
      if (gnt[i]) begin
        vec      = vec | class_vec(i);
        save_nxt = save_nxt | class_next(i);
      end
    end
    imprecise = gnt[C_CDACL] | gnt[C_CDACU];
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_hit,
  input  logic             trap_as_dbg,
  input  logic             syscall,
  input  logic             vfp_data,
  input  logic             vfp_round,
  input  logic             lsm_misalign,
  input  logic             bzero_nocache,
  input  logic             tlb_miss,
  input  logic             acc_violation,
  input  logic             endian_split,
  input  logic             bus_err,
  input  logic             ext_int_en,
  input  logic             dbg_enable,
  input  logic             dbg_internal_mode,
  input  logic [4:0]       ev_en,
  input  logic             ev_irq_taken,
  input  logic             ev_crit_taken,
  input  logic             crit_irq,
  input  logic             ev_dac_linked,
  input  logic             ev_dac_unlinked,
  input  logic             ev_icmp,
  input  logic             ide_clr,
  output logic             take,
  output logic [13:0]      win_onehot,
  output logic [5:0]       vec_idx,
  output logic             save_next,
  output logic             ide_flag
);
  cls_vec_t         req, gnt;
  logic             any_req;
  logic [VEC_W-1:0] vec_c;
  logic             nxt_c, imp_c;

  exc_req_qualify u_qual (
    .trap_hit          (trap_hit),
    .trap_as_dbg       (trap_as_dbg),
    .syscall           (syscall),
    .vfp_data          (vfp_data),
    .vfp_round         (vfp_round),
    .lsm_misalign      (lsm_misalign),
    .bzero_nocache     (bzero_nocache),
    .tlb_miss          (tlb_miss),
    .acc_violation     (acc_violation),
    .endian_split      (endian_split),
    .bus_err           (bus_err),
    .ext_int_en        (ext_int_en),
    .dbg_enable        (dbg_enable),
    .dbg_internal_mode (dbg_internal_mode),
    .ev_en             (ev_en),
    .ev_irq_taken      (ev_irq_taken),
    .ev_crit_taken     (ev_crit_taken),
    .crit_irq          (crit_irq),
    .ev_dac_linked     (ev_dac_linked),
    .ev_dac_unlinked   (ev_dac_unlinked),
    .ev_icmp           (ev_icmp),
    .req               (req)
  );

  exc_prio_pick #(.N(NCLS)) u_pick (
    .req (req),
    .gnt (gnt),
    .any (any_req)
  );

  exc_vec_encode u_enc (
    .gnt       (gnt),
    .vec       (vec_c),
    .save_nxt  (nxt_c),
    .imprecise (imp_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take       <= 1'b0;
      win_onehot <= '0;
      vec_idx    <= '0;
      save_next  <= 1'b0;
      ide_flag   <= 1'b0;
    end else begin
      take       <= any_req;
      win_onehot <= gnt;
      vec_idx    <= vec_c;
      save_next  <= nxt_c;
      ide_flag   <= imp_c | (ide_flag & ~ide_clr);
    end
  end
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [17:0] raw,
  input logic        dbg_ok,
  input logic        ide_clr,
  input logic        take,
  input logic [13:0] win_onehot,
  input logic [5:0]  vec_idx,
  input logic        save_next,
  input logic        ide_flag
);
  p_one_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_onehot) == (take ? 1 : 0));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == '0) |=> !take);

  p_dbg_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_ok |=> !(take && vec_idx == 6'd15));

  p_ide_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_flag && !ide_clr) |=> ide_flag);

  p_ide_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ide_flag) |-> (take && vec_idx == 6'd15 && !save_next));

  p_fault_cur_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (vec_idx == 6'd13 || vec_idx == 6'd2 || vec_idx == 6'd5)) |-> !save_next);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!take && !ide_flag);
    end
  end
endmodule

bind exc_arbiter exc_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .raw        ({trap_hit, syscall, vfp_data, vfp_round, lsm_misalign, bzero_nocache,
                tlb_miss, acc_violation, endian_split, bus_err, ev_irq_taken,
                ev_crit_taken, ev_dac_linked, ev_dac_unlinked, ev_icmp,
                trap_as_dbg, crit_irq, ext_int_en}),
  .dbg_ok     (dbg_enable & dbg_internal_mode),
  .ide_clr    (ide_clr),
  .take       (take),
  .win_onehot (win_onehot),
  .vec_idx    (vec_idx),
  .save_next  (save_next),
  .ide_flag   (ide_flag)
);

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_hit, trap_as_dbg, syscall, vfp_data, vfp_round;
  logic lsm_misalign, bzero_nocache, tlb_miss, acc_violation, endian_split;
  logic bus_err, ext_int_en, dbg_enable, dbg_internal_mode;
  logic [4:0] ev_en;
  logic ev_irq_taken, ev_crit_taken, crit_irq, ev_dac_linked, ev_dac_unlinked, ev_icmp;
  logic ide_clr;
  logic take, save_next, ide_flag;
  logic [13:0] win_onehot;
  logic [5:0] vec_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_arbiter u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    trap_hit = 0; trap_as_dbg = 0; syscall = 0; vfp_data = 0; vfp_round = 0;
    lsm_misalign = 0; bzero_nocache = 0; tlb_miss = 0; acc_violation = 0;
    endian_split = 0; bus_err = 0; ext_int_en = 0; dbg_enable = 1;
    dbg_internal_mode = 1; ev_en = 5'b11111; ev_irq_taken = 0; ev_crit_taken = 0;
    crit_irq = 0; ev_dac_linked = 0; ev_dac_unlinked = 0; ev_icmp = 0; ide_clr = 0;
  endtask

  // one edge, then check; bit < 0 means no winner expected
  task automatic expect_win(input string tag, input int bit_i, input int vec, input int nxt);
    @(posedge clk); #1;
    if (bit_i < 0) begin
      chk({tag, " take"}, int'(take), 0);
      chk({tag, " onehot"}, int'(win_onehot), 0);
    end else begin
      chk({tag, " take"}, int'(take), 1);
      chk({tag, " onehot"}, int'(win_onehot), 1 << bit_i);
      chk({tag, " vec"}, int'(vec_idx), vec);
      chk({tag, " save"}, int'(save_next), nxt);
    end
    quiet();
  endtask

  task automatic clear_ide();
    ide_clr = 1; @(posedge clk); #1; quiet();
  endtask

  task automatic t_reset();
    chk("R1 take", int'(take), 0);
    chk("R1 vec", int'(vec_idx), 0);
    chk("R1 save", int'(save_next), 0);
    chk("R1 ide", int'(ide_flag), 0);
    chk("R1 onehot", int'(win_onehot), 0);
  endtask

  task automatic t_each_alone();
    trap_hit = 1;        expect_win("R4 trap", 0, 6, 0);
    syscall = 1;         expect_win("R13 sc", 1, 8, 1);
    vfp_data = 1;        expect_win("R4 vfpd", 2, 33, 0);
    vfp_round = 1;       expect_win("R4 vfpr", 3, 34, 0);
    lsm_misalign = 1;    expect_win("R8 lsm", 4, 5, 0);
    tlb_miss = 1;        expect_win("R4 tlb", 7, 13, 0);
    acc_violation = 1;   expect_win("R9 acc", 8, 2, 0);
    ev_irq_taken = 1;    expect_win("R4 dirq", 9, 15, 0);
    ev_crit_taken = 1; crit_irq = 1; expect_win("R11 dcirq", 10, 15, 0);
    ev_icmp = 1;         expect_win("R13 icmp", 13, 15, 1);
    expect_win("R2 idle", -1, 0, 0);
  endtask

  task automatic t_priority();
    trap_hit = 1; syscall = 1; vfp_data = 1; vfp_round = 1; lsm_misalign = 1;
    tlb_miss = 1; ev_dac_linked = 1; ev_icmp = 1;
    expect_win("R3 all", 0, 6, 0);
    clear_ide();
    syscall = 1; vfp_data = 1;   expect_win("R3 sc>vfpd", 1, 8, 1);
    vfp_data = 1; vfp_round = 1; expect_win("R3 vfpd>vfpr", 2, 33, 0);
    vfp_round = 1; bzero_nocache = 1; expect_win("R3 vfpr>align", 3, 34, 0);
    lsm_misalign = 1; tlb_miss = 1; ev_dac_linked = 1; expect_win("R3 align>cdac", 4, 5, 0);
    chk("R3 ide untouched", int'(ide_flag), 0);
    tlb_miss = 1; acc_violation = 1; expect_win("R3 tlb>dstor", 7, 13, 0);
    endian_split = 1; ev_irq_taken = 1; expect_win("R3 dstor>dirq", 8, 2, 0);
    ev_irq_taken = 1; ev_crit_taken = 1; crit_irq = 1; expect_win("R11 irq>crit", 9, 15, 0);
    ev_crit_taken = 1; crit_irq = 1; ev_dac_linked = 1; expect_win("R3 crit>pdac", 10, 15, 0);
    ev_dac_unlinked = 1; ev_icmp = 1; expect_win("R3 pdacu>icmp", 12, 15, 1);
  endtask

  task automatic t_concurrent();
    tlb_miss = 1; ev_dac_linked = 1;
    expect_win("R6 cdacl tlb", 5, 15, 0);
    chk("R6 ide set", int'(ide_flag), 1);
    expect_win("R12 idle hold", -1, 0, 0);
    chk("R12 ide hold", int'(ide_flag), 1);
    clear_ide();
    chk("R12 ide cleared", int'(ide_flag), 0);
    acc_violation = 1; ev_dac_unlinked = 1;
    expect_win("R6 cdacu dstor", 6, 15, 0);
    chk("R6 ide set unlinked", int'(ide_flag), 1);
    tlb_miss = 1; ev_dac_linked = 1; ev_dac_unlinked = 1; ide_clr = 1;
    expect_win("R6 linked>unlinked", 5, 15, 0);
    chk("R12 set beats clear", int'(ide_flag), 1);
    clear_ide();
  endtask

  task automatic t_post_dac();
    ev_dac_linked = 1;   expect_win("R7 pdacl", 11, 15, 1);
    ev_dac_unlinked = 1; expect_win("R7 pdacu", 12, 15, 1);
    ev_dac_linked = 1; ev_dac_unlinked = 1; expect_win("R7 linked>unlinked", 11, 15, 1);
    chk("R7 ide unchanged", int'(ide_flag), 0);
  endtask

  task automatic t_dbg_gate();
    ev_icmp = 1; dbg_enable = 0;        expect_win("R5 no msr de", -1, 0, 0);
    ev_icmp = 1; dbg_internal_mode = 0; expect_win("R5 no idm", -1, 0, 0);
    ev_icmp = 1; ev_en = 5'b01111;      expect_win("R5 icmp en off", -1, 0, 0);
    ev_irq_taken = 1; ev_en = 5'b11110; expect_win("R5 irq en off", -1, 0, 0);
    tlb_miss = 1; ev_dac_linked = 1; ev_en = 5'b11011;
    expect_win("R5 cdac off -> tlb", 7, 13, 0);
    chk("R5 ide stays", int'(ide_flag), 0);
    tlb_miss = 1; ev_dac_linked = 1; dbg_enable = 0;
    expect_win("R5 de off -> tlb", 7, 13, 0);
  endtask

  task automatic t_sources();
    bzero_nocache = 1;          expect_win("R8 bzero", 4, 5, 0);
    endian_split = 1;           expect_win("R9 endian", 8, 2, 0);
    bus_err = 1; ext_int_en = 1; expect_win("R9 bus ee1", 8, 2, 0);
    bus_err = 1;                expect_win("R9 bus ee0", -1, 0, 0);
    trap_hit = 1; trap_as_dbg = 1; expect_win("R10 trap dbg", -1, 0, 0);
    trap_hit = 1; trap_as_dbg = 1; syscall = 1; expect_win("R10 trap dbg sc", 1, 8, 1);
    ev_crit_taken = 1;          expect_win("R11 crit noncrit", -1, 0, 0);
  endtask

  initial begin
    quiet();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_each_alone();
    t_priority();
    t_concurrent();
    t_post_dac();
    t_dbg_gate();
    t_sources();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule